// File: doc/BRIEF.md
# ECG QRS Detector and Heart-Rate Meter

This block takes a stream of signed ECG samples and finds the QRS complexes in it. For each accepted sample it forms a nonlinear slope feature: the absolute first difference plus the absolute second difference. It smooths that feature with a first-order recursive low-pass filter whose gain is a power of two. A beat is declared at a local maximum of the smoothed feature that lies above an adaptive threshold. A programmable refractory window then blocks any new beat for a set number of samples.

The block counts the samples between consecutive beats and turns that count into a heart rate in beats per minute. A sequential divider computes sample rate × 60 / interval, and the result is clamped to 255. Each detected beat raises a one-cycle strobe. Each computed rate is offered on a valid/ready output.

Samples enter on a valid/ready input. A sample transfers on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` drops from the cycle after a beat that starts a division. It stays low until the resulting rate has been taken with `m_valid` and `m_ready` both high. While `s_ready` is low, the source must hold its sample. Once `m_valid` rises, it stays high with `m_bpm` unchanged until `m_ready` is seen.

Top module: `qrs_rate_meter`

## Requirements
- R1: After reset the sample history x(n−1) and x(n−2) is zero. For each accepted sample x(n), the feature is f(n) = |x(n) − x(n−1)| + |x(n) − 2·x(n−1) + x(n−2)|.
- R2: The smoothed value starts at zero and updates once per accepted sample as s(n) = s(n−1) + floor((f(n) − s(n−1)) / 2^ASH), where ASH = 3 by default.
- R3: A beat is detected on accepted sample n when three conditions hold: s(n−1) > T, s(n) < s(n−1), and the block is armed. `beat_pulse` is high for exactly the one cycle after the edge that accepted that sample.
- R4: Until four beats have been detected, T equals `cfg_thr_init`. After that, T equals floor(sum of the s(n−1) values recorded at the last four beats / 8), which is half their mean. A beat's own value counts from the next sample onwards.
- R5: Before the first beat the block is always armed. After a beat it is armed on sample n only if the samples since that beat, counting n itself, number at least `cfg_refr`.
- R6: The interval of a beat is the number of accepted samples from the previous beat up to and including this one. The counter saturates at 65535. The first beat after reset produces no rate.
- R7: Every beat after the first produces `m_bpm` = min(floor(FS·60 / interval), 255), with FS = 500 by default.
- R8: `m_valid` with `m_bpm` holds steady until accepted by `m_ready`. From the cycle after a rate-producing beat until that handshake, `s_ready` is low.
- R9: During and right after reset, `s_ready` is 1 and both `m_valid` and `beat_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_data | input | 12 | Signed ECG sample |
| cfg_refr | input | 16 | Refractory length in samples |
| cfg_thr_init | input | 14 | Threshold used before four beats are recorded |
| beat_pulse | output | 1 | One-cycle strobe per detected beat |
| m_valid | output | 1 | Heart-rate result valid |
| m_ready | input | 1 | Consumer takes the result |
| m_bpm | output | 8 | Heart rate in beats per minute |

## Verification
The stimulus puts a second spike inside the refractory window. A design that ignored the window would report an extra beat and a high rate. Short beat periods drive the rate past 255; a design without the clamp would report a wrapped, small value. The threshold switches from the initial value to the peak average on the fifth beat, so a history off by one peak would shift which samples detect. Random stalls on `m_ready` show whether the result stays stable and the input stays closed while the rate waits.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  typedef enum logic [1:0] {DV_IDLE, DV_RUN, DV_DONE} div_state_t;

  localparam int unsigned PEAK_HIST = 4;
endpackage

// File: rtl/qrs_feature.sv
module qrs_feature #(
  parameter int SAMPLE_W = 12,
  parameter int ASH      = 3,
  localparam int FW      = SAMPLE_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [FW-1:0]       sm_q,
  output logic [FW-1:0]       sm_nxt
);
  localparam int EW = SAMPLE_W + 3;

  logic signed [EW-1:0] xe, x1e, x2e, d1, d2, a1, a2;
  logic [FW-1:0]        feat;
  logic signed [FW:0]   delta, step, acc;

  assign xe = {{3{sample[SAMPLE_W-1]}}, sample};
  assign d1 = xe - x1e;
  assign d2 = xe - (x1e <<< 1) + x2e;
  assign a1 = d1[EW-1] ? -d1 : d1;
  assign a2 = d2[EW-1] ? -d2 : d2;
  assign feat = FW'(a1) + FW'(a2);

  assign delta  = $signed({1'b0, feat}) - $signed({1'b0, sm_q});
  assign step   = delta >>> ASH;
  assign acc    = $signed({1'b0, sm_q}) + step;
  assign sm_nxt = FW'(acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x1e  <= '0;
      x2e  <= '0;
      sm_q <= '0;
    end else if (fire) begin
      x1e  <= xe;
      x2e  <= x1e;
      sm_q <= sm_nxt;
    end
  end
endmodule

// File: rtl/qrs_peak.sv
module qrs_peak #(
  parameter int FW    = 14,
  parameter int CNT_W = 16,
  parameter int PK_N  = qrs_pkg::PEAK_HIST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [FW-1:0]    sm_prev,
  input  logic [FW-1:0]    sm_cur,
  input  logic [FW-1:0]    cfg_thr_init,
  input  logic [CNT_W-1:0] cfg_refr,
  output logic             beat,
  output logic             start,
  output logic [CNT_W-1:0] interval
);
  localparam int LG   = $clog2(PK_N);
  localparam int SW   = FW + LG;
  localparam int NW   = $clog2(PK_N + 1);
  localparam int SHR  = LG + 1;

  logic [FW-1:0]    pk [PK_N];
  logic [NW-1:0]    npk;
  logic [CNT_W-1:0] cnt, cnt_next;
  logic             have_beat, armed, detect;
  logic [SW-1:0]    pk_sum;
  logic [FW-1:0]    thr;

  always_comb begin
    pk_sum = '0;
    for (int i = 0; i < PK_N; i++) pk_sum = pk_sum + SW'(pk[i]);
  end

  assign thr      = (npk == NW'(PK_N)) ? FW'(pk_sum >> SHR) : cfg_thr_init;
  assign cnt_next = (cnt == {CNT_W{1'b1}}) ? cnt : cnt + 1'b1;
  assign armed    = !have_beat || (cnt_next >= cfg_refr);
  assign detect   = fire && armed && (sm_prev > thr) && (sm_cur < sm_prev);

  always_ff @(posedge clk) begin
    if (!rst_n) pk[0] <= '0;
    else if (detect) pk[0] <= sm_prev;
  end

  for (genvar g = 1; g < PK_N; g++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) pk[g] <= '0;
      else if (detect) pk[g] <= pk[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      have_beat <= 1'b0;
      npk       <= '0;
      beat      <= 1'b0;
      start     <= 1'b0;
      interval  <= '0;
    end else begin
      beat  <= detect;
      start <= detect && have_beat;
      if (fire) cnt <= detect ? '0 : cnt_next;
      if (detect) begin
        have_beat <= 1'b1;
        if (npk != NW'(PK_N)) npk <= npk + 1'b1;
        if (have_beat) interval <= cnt_next;
      end
    end
  end

  // R5: a division is only started for an interval at least the refractory length
  p_intv_refr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (interval >= cfg_refr));
  // R6: a measured interval is never zero
  p_intv_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (interval != '0));
endmodule

// File: rtl/qrs_div.sv
module qrs_div #(
  parameter int DVD_W = 15,
  parameter int CNT_W = 16,
  parameter int unsigned DVD = 30000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DVD_W-1:0] quot
);
  import qrs_pkg::*;
  localparam int IT_W = $clog2(DVD_W + 1);

  div_state_t       st;
  logic [CNT_W-1:0] rem, dvs;
  logic [IT_W-1:0]  it;
  logic [CNT_W:0]   rem_sh;
  logic             ge;

  assign rem_sh = {rem, quot[DVD_W-1]};
  assign ge     = rem_sh >= {1'b0, dvs};
  assign busy   = (st != DV_IDLE);
  assign done   = (st == DV_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= DV_IDLE;
      rem  <= '0;
      dvs  <= '0;
      quot <= '0;
      it   <= '0;
    end else begin
      case (st)
        DV_IDLE: if (start) begin
          rem  <= '0;
          dvs  <= divisor;
          quot <= DVD_W'(DVD);
          it   <= IT_W'(DVD_W);
          st   <= DV_RUN;
        end
        DV_RUN: begin
          rem  <= ge ? CNT_W'(rem_sh - {1'b0, dvs}) : CNT_W'(rem_sh);
          quot <= {quot[DVD_W-2:0], ge};
          it   <= it - 1'b1;
          if (it == IT_W'(1)) st <= DV_DONE;
        end
        default: st <= DV_IDLE;
      endcase
    end
  end

  // R7: the final remainder is smaller than the divisor
  p_div_rem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem < dvs));
  // R8: input flow control never lets a second division start while one runs
  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/qrs_rate_meter.sv
module qrs_rate_meter #(
  parameter int SAMPLE_W = 12,
  parameter int ASH      = 3,
  parameter int FS       = 500,
  parameter int CNT_W    = 16,
  parameter int BPM_W    = 8,
  localparam int FW      = SAMPLE_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic [CNT_W-1:0]    cfg_refr,
  input  logic [FW-1:0]       cfg_thr_init,
  output logic                beat_pulse,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [BPM_W-1:0]    m_bpm
);
  localparam int unsigned RATE_K  = FS * 60;
  localparam int          DVD_W   = $clog2(RATE_K + 1);
  localparam int unsigned BPM_MAX = (1 << BPM_W) - 1;

  logic             s_fire, div_start, div_busy, div_done;
  logic [FW-1:0]    sm_q, sm_nxt;
  logic [CNT_W-1:0] intv;
  logic [DVD_W-1:0] quot;

  assign s_ready = !(div_start || div_busy || m_valid);
  assign s_fire  = s_valid && s_ready;

  qrs_feature #(.SAMPLE_W(SAMPLE_W), .ASH(ASH)) u_feat (
    .clk(clk), .rst_n(rst_n), .fire(s_fire), .sample(s_data),
    .sm_q(sm_q), .sm_nxt(sm_nxt)
  );

  qrs_peak #(.FW(FW), .CNT_W(CNT_W)) u_peak (
    .clk(clk), .rst_n(rst_n), .fire(s_fire), .sm_prev(sm_q), .sm_cur(sm_nxt),
    .cfg_thr_init(cfg_thr_init), .cfg_refr(cfg_refr),
    .beat(beat_pulse), .start(div_start), .interval(intv)
  );

  qrs_div #(.DVD_W(DVD_W), .CNT_W(CNT_W), .DVD(RATE_K)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .divisor(intv),
    .busy(div_busy), .done(div_done), .quot(quot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_bpm   <= '0;
    end else if (div_done) begin
      m_valid <= 1'b1;
      m_bpm   <= (32'(quot) > BPM_MAX) ? BPM_W'(BPM_MAX) : BPM_W'(quot);
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R8: a pending result is held unchanged until taken
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_bpm)));
  // R3: a beat strobe follows an accepted sample
  p_beat_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_pulse |-> $past(s_valid && s_ready));
endmodule

// File: tb/tb_qrs_rate_meter.sv
`timescale 1ns/1ps
module tb_qrs_rate_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_data = '0;
  logic [15:0] cfg_refr = 16'd100;
  logic [13:0] cfg_thr_init = 14'd60;
  logic        beat_pulse, m_valid;
  logic        m_ready = 1'b0;
  logic [7:0]  m_bpm;

  int checks = 0, fails = 0, cyc = 0;
  bit done_flag = 0;
  int n_beats = 0, n_rates = 0, n_sat = 0;

  int mx1 = 0, mx2 = 0, my4 = 0, mcnt = 0, mnpk = 0;
  bit mhave = 0;
  int mpk [4] = '{0, 0, 0, 0};

  always #4 clk = ~clk;

  qrs_rate_meter dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .cfg_refr(cfg_refr), .cfg_thr_init(cfg_thr_init),
    .beat_pulse(beat_pulse), .m_valid(m_valid), .m_ready(m_ready), .m_bpm(m_bpm)
  );

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int rate_of(input int intv);
    int q = 30000 / intv;
    return (q > 255) ? 255 : q;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
    end
  end

  task automatic send(input int v);
    int y3, y4n, cn, thr, sum, bpm;
    bit det, has_rate;
    // reference model for R1 R2 R3 R4 R5 R6 R7
    y3  = iabs(v - mx1) + iabs(v - 2 * mx1 + mx2);
    y4n = my4 + ((y3 - my4) >>> 3);
    cn  = (mcnt == 65535) ? mcnt : mcnt + 1;
    sum = mpk[0] + mpk[1] + mpk[2] + mpk[3];
    thr = (mnpk == 4) ? (sum >>> 3) : int'(cfg_thr_init);
    det = (!mhave || cn >= int'(cfg_refr)) && (my4 > thr) && (y4n < my4);
    has_rate = det && mhave;
    bpm = has_rate ? rate_of(cn) : 0;
    if (det) begin
      mpk[3] = mpk[2]; mpk[2] = mpk[1]; mpk[1] = mpk[0]; mpk[0] = my4;
      if (mnpk < 4) mnpk++;
      mhave = 1;
      mcnt = 0;
    end else begin
      mcnt = cn;
    end
    mx2 = mx1; mx1 = v; my4 = y4n;

    while (!s_ready) @(negedge clk);
    s_valid = 1'b1;
    s_data = v[11:0];
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    check(beat_pulse == det, "R1 R2 R3 R4 R5 beat", int'(beat_pulse), int'(det));
    if (det) n_beats++;
    if (has_rate) begin
      check(s_ready == 1'b0, "R8 input closed", int'(s_ready), 0);
      while (!m_valid) @(negedge clk);
      check(int'(m_bpm) == bpm, "R6 R7 rate", int'(m_bpm), bpm);
      n_rates++;
      if (bpm == 255) n_sat++;
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
        @(negedge clk);
        check(m_valid && int'(m_bpm) == bpm && !s_ready, "R8 hold", int'(m_bpm), bpm);
      end
      m_ready = 1'b1;
      @(negedge clk);
      m_ready = 1'b0;
      check(m_valid == 1'b0, "R8 handshake", int'(m_valid), 0);
    end
  endtask

  task automatic noise(input int n);
    for (int i = 0; i < n; i++) send(int'($urandom_range(0, 10)) - 5);
  endtask

  task automatic spike(input int h);
    for (int i = 1; i <= 4; i++) send(h * i / 4);
    for (int i = 3; i >= 0; i--) send(h * i / 4);
  endtask

  task automatic train(input int period, input int h, input int count);
    for (int b = 0; b < count; b++) begin
      spike(h);
      noise(period - 8);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(s_ready == 1'b1 && m_valid == 1'b0 && beat_pulse == 1'b0, "R9 reset",
          int'({s_ready, m_valid, beat_pulse}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready == 1'b1 && m_valid == 1'b0 && beat_pulse == 1'b0, "R9 after reset",
          int'({s_ready, m_valid, beat_pulse}), 4);

    noise(40);
    train(250, 1200, 6);                       // steady rhythm, threshold handover (R4)
    for (int b = 0; b < 20; b++)               // random rhythm and amplitude
      train(int'($urandom_range(150, 500)), int'($urandom_range(600, 1800)), 1);

    // R5: secondary spike inside the refractory window must be ignored
    cfg_refr = 16'd150;
    for (int b = 0; b < 5; b++) begin
      spike(1400);
      noise(52);
      spike(1400);
      noise(200);
    end

    // R7: short intervals clamp to 255
    cfg_refr = 16'd5;
    train(40, 1500, 8);

    // negative-going complexes
    cfg_refr = 16'd100;
    train(300, -1500, 5);

    check(n_beats > 20, "R3 beats seen", n_beats, 21);
    check(n_rates > 10, "R6 rates seen", n_rates, 11);
    check(n_sat > 0, "R7 clamp seen", n_sat, 1);
    summary();
  end
endmodule